// File: doc/BRIEF.md
# Register-Access Transaction Sequencer for a Two-Wire Bus Master

This block turns one request into a full register-addressed transfer on a two-wire serial bus. A request carries a 7-bit target address, a direction, a count of register-address bytes (0 to 4, taken from the low end of a 32-bit value) and a data byte count. The block drives a byte-level bus engine one command at a time. A command is START plus a byte, a plain byte write, a byte read with a chosen acknowledge, or STOP. Every command is held until the engine reports it done.

Write data is pulled from a valid/ready stream, one byte just before each data write. Read data leaves as a byte with a one-cycle valid strobe. A read that has register-address bytes uses a combined format: it writes the address, issues a repeated START in the read direction, then receives the data. The last received byte is not acknowledged, and that is a normal end. Any transfer that reached the bus is closed with STOP, including failed ones. A one-byte read with no address bytes serves as a presence probe. At the end the block pulses `done` and reports one of four status codes.

Top module: `i2c_regxfer_seq`

## Requirements
- R1: A request with a data count of 0, or with more than 4 register-address bytes, ends on the next cycle with `done` and status 3 (bad request), and issues no engine command.
- R2: No engine command is issued while `bus_busy` is high before the first START. If `bus_busy` stays high for `BUSY_TMO_CYC` cycles, the request ends with status 2 (timeout) and issues no command.
- R3: The first command is START (code 1) with the byte {target, dir}. dir is 1 only for a read with no register-address bytes.
- R4: Register-address bytes go out as WRITE commands (code 2), most significant first. Only the low `alen` bytes of the 32-bit address are used, and `alen` = 0 skips this phase.
- R5: A read with register-address bytes issues a second START with {target, 1} after the last address byte and before the first READ (code 3).
- R6: Each READ command has `bc_ack_en` = 1 except the final one, which has 0. Each completed READ produces one `rd_valid` pulse carrying the received byte. A not-acknowledged final read still gives status 0 (OK).
- R7: A not-acknowledged START or WRITE, or a not-acknowledged READ before the final one, ends the transfer with status 1 (NACK).
- R8: A command not completed within `BYTE_TMO_CYC` cycles ends the transfer with status 2 (timeout).
- R9: Every transfer that issued a START ends with a STOP command (code 4) before its one-cycle `done` pulse.
- R10: In a write, `wr_ready` is high only while a byte is awaited. It stays high until `wr_valid`, and each accepted byte is sent in a WRITE in stream order.
- R11: With 1 to 3 address bytes, address bits above those sent, ANDed with `DEV_OVF_MASK`, are ORed into the target address of both STARTs.
- R12: A probe (read, 1 byte, no address bytes) gives status 0 when its START is acknowledged, and status 1 with START then STOP only when it is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Request strobe, taken while idle |
| req_dev | input | 7 | Target address |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_alen | input | 3 | Register-address byte count |
| req_addr | input | 32 | Register address |
| req_len | input | 16 | Data byte count |
| busy | output | 1 | Request in progress |
| wr_valid | input | 1 | Write byte available |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Write byte accepted this cycle when valid |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle end-of-request pulse |
| status | output | 2 | 0 OK, 1 NACK, 2 timeout, 3 bad request |
| bus_busy | input | 1 | Bus occupied by another transfer |
| bc_cmd_valid | output | 1 | Engine command held until done |
| bc_cmd | output | 3 | 1 START, 2 WRITE, 3 READ, 4 STOP |
| bc_txbyte | output | 8 | Byte for START or WRITE |
| bc_ack_en | output | 1 | Acknowledge the byte of a READ |
| bc_done | input | 1 | Engine finished the command |
| bc_nack | input | 1 | Acknowledge bit seen was high |
| bc_rxbyte | input | 8 | Byte received by a READ |

## Verification
The main path runs with writes of two address bytes while the write stream stalls, and with combined reads of one and of four address bytes. It also runs probes that are acknowledged and not acknowledged. Together these separate the direction bit of the first START, the presence of the repeated START and the acknowledge pattern of the reads. A not-acknowledged address byte, a not-acknowledged middle read and a stalled write byte each show that the command list stops where the fault is and still ends with STOP. The overflow cases contrast one address byte, where the upper bits enter the target address, with four, where they do not.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int ADDR_BYTES = 4;
    localparam int IDX_W      = $clog2(ADDR_BYTES);
    localparam int LEN_W      = 16;

    typedef enum logic [2:0] {
        BC_NONE  = 3'd0,
        BC_START = 3'd1,
        BC_WRITE = 3'd2,
        BC_READ  = 3'd3,
        BC_STOP  = 3'd4
    } bc_cmd_e;

    typedef enum logic [1:0] {
        XS_OK   = 2'd0,
        XS_NACK = 2'd1,
        XS_TMO  = 2'd2,
        XS_BAD  = 2'd3
    } xfer_status_e;

    typedef enum logic [3:0] {
        S_IDLE, S_BUSW, S_DEV, S_ADR, S_RS, S_WFETCH, S_WR, S_RD, S_STOP, S_FIN
    } seq_state_e;

    typedef struct packed {
        logic [6:0]                dev;
        logic                      rnw;
        logic [2:0]                alen;
        logic [8*ADDR_BYTES-1:0]   addr;
        logic [LEN_W-1:0]          len;
    } xfer_req_t;

    // Fold address bits above the sent bytes into the target address.
    function automatic logic [6:0] fold_dev(input logic [6:0] dev,
                                            input logic [8*ADDR_BYTES-1:0] addr,
                                            input logic [2:0] alen,
                                            input logic [6:0] mask);
        logic [8*ADDR_BYTES-1:0] hi;
        hi = addr >> {alen, 3'b000};
        if (alen == 3'd0)
            return dev;
        return dev | (mask & hi[6:0]);
    endfunction

endpackage

// File: rtl/i2cs_tmo.sv
module i2cs_tmo #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    assign expired = (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (en && !expired)
            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/i2cs_abyte.sv
module i2cs_abyte
    import i2cs_pkg::*;
(
    input  logic [8*ADDR_BYTES-1:0] addr,
    input  logic [IDX_W-1:0]        idx,
    output logic [7:0]              byte_o
);
    logic [7:0] lane [ADDR_BYTES];

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
        assign lane[g] = addr[8*g +: 8];
    end

    assign byte_o = lane[idx];
endmodule

// File: rtl/i2c_regxfer_seq.sv
module i2c_regxfer_seq
    import i2cs_pkg::*;
#(
    parameter int         BUSY_TMO_CYC = 100_000_000,
    parameter int         BYTE_TMO_CYC = 100_000_000,
    parameter logic [6:0] DEV_OVF_MASK = 7'h00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_start,
    input  logic [6:0]  req_dev,
    input  logic        req_rnw,
    input  logic [2:0]  req_alen,
    input  logic [31:0] req_addr,
    input  logic [15:0] req_len,
    output logic        busy,
    input  logic        wr_valid,
    input  logic [7:0]  wr_data,
    output logic        wr_ready,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        done,
    output logic [1:0]  status,
    input  logic        bus_busy,
    output logic        bc_cmd_valid,
    output logic [2:0]  bc_cmd,
    output logic [7:0]  bc_txbyte,
    output logic        bc_ack_en,
    input  logic        bc_done,
    input  logic        bc_nack,
    input  logic [7:0]  bc_rxbyte
);
    seq_state_e   st, nx;
    xfer_status_e stat_q, stat_d;
    xfer_req_t    rq;
    logic [6:0]       dev_eff;
    logic [IDX_W-1:0] aidx;
    logic [LEN_W-1:0] cnt;
    logic [7:0]       wbyte;
    logic [7:0]       abyte;
    logic             rd_valid_q;
    logic [7:0]       rd_data_q;
    logic             busy_exp, byte_exp;
    logic             last_data;
    logic             cmd_state;
    bc_cmd_e          cmd;

    i2cs_tmo #(.LIMIT(BUSY_TMO_CYC)) u_busy_tmo (
        .clk(clk), .rst(rst), .clr(st != S_BUSW), .en(st == S_BUSW), .expired(busy_exp)
    );

    i2cs_tmo #(.LIMIT(BYTE_TMO_CYC)) u_byte_tmo (
        .clk(clk), .rst(rst), .clr((nx != st) || bc_done), .en(cmd_state), .expired(byte_exp)
    );

    i2cs_abyte u_abyte (.addr(rq.addr), .idx(aidx), .byte_o(abyte));

    assign last_data = (cnt == rq.len - LEN_W'(1));

    always_comb begin
        cmd = BC_NONE;
        unique case (st)
            S_DEV, S_RS: cmd = BC_START;
            S_ADR, S_WR: cmd = BC_WRITE;
            S_RD:        cmd = BC_READ;
            S_STOP:      cmd = BC_STOP;
            default:     cmd = BC_NONE;
        endcase
    end

    assign cmd_state    = (cmd != BC_NONE);
    assign bc_cmd_valid = cmd_state;
    assign bc_cmd       = cmd;
    assign bc_ack_en    = (st == S_RD) && !last_data;
    assign wr_ready     = (st == S_WFETCH);
    assign busy         = (st != S_IDLE);
    assign done         = (st == S_FIN);
    assign status       = stat_q;
    assign rd_valid     = rd_valid_q;
    assign rd_data      = rd_data_q;

    always_comb begin
        unique case (st)
            S_DEV:   bc_txbyte = {dev_eff, rq.rnw && (rq.alen == 3'd0)};
            S_RS:    bc_txbyte = {dev_eff, 1'b1};
            S_ADR:   bc_txbyte = abyte;
            S_WR:    bc_txbyte = wbyte;
            default: bc_txbyte = 8'h00;
        endcase
    end

    // Next state and status.
    always_comb begin
        nx     = st;
        stat_d = stat_q;
        unique case (st)
            S_IDLE: if (req_start) begin
                if (req_len == '0 || req_alen > 3'(ADDR_BYTES)) begin
                    stat_d = XS_BAD;
                    nx     = S_FIN;
                end else begin
                    stat_d = XS_OK;
                    nx     = S_BUSW;
                end
            end
            S_BUSW: if (!bus_busy) begin
                nx = S_DEV;
            end else if (busy_exp) begin
                stat_d = XS_TMO;
                nx     = S_FIN;
            end
            S_DEV: if (bc_done) begin
                if (bc_nack) begin
                    stat_d = XS_NACK;
                    nx     = S_STOP;
                end else if (rq.alen != 3'd0)
                    nx = S_ADR;
                else if (rq.rnw)
                    nx = S_RD;
                else
                    nx = S_WFETCH;
            end
            S_ADR: if (bc_done) begin
                if (bc_nack) begin
                    stat_d = XS_NACK;
                    nx     = S_STOP;
                end else if (aidx == '0)
                    nx = rq.rnw ? S_RS : S_WFETCH;
            end
            S_RS: if (bc_done) begin
                if (bc_nack) begin
                    stat_d = XS_NACK;
                    nx     = S_STOP;
                end else
                    nx = S_RD;
            end
            S_WFETCH: if (wr_valid) nx = S_WR;
            S_WR: if (bc_done) begin
                if (bc_nack) begin
                    stat_d = XS_NACK;
                    nx     = S_STOP;
                end else if (last_data)
                    nx = S_STOP;
                else
                    nx = S_WFETCH;
            end
            S_RD: if (bc_done) begin
                if (last_data)
                    nx = S_STOP;
                else if (bc_nack) begin
                    stat_d = XS_NACK;
                    nx     = S_STOP;
                end
            end
            S_STOP: if (bc_done || byte_exp) nx = S_FIN;
            S_FIN:  nx = S_IDLE;
            default: nx = S_IDLE;
        endcase
        if (cmd_state && st != S_STOP && !bc_done && byte_exp) begin
            stat_d = XS_TMO;
            nx     = S_STOP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            stat_q     <= XS_OK;
            rq         <= '0;
            dev_eff    <= '0;
            aidx       <= '0;
            cnt        <= '0;
            wbyte      <= '0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            st         <= nx;
            stat_q     <= stat_d;
            rd_valid_q <= 1'b0;
            unique case (st)
                S_IDLE: if (req_start) begin
                    rq      <= '{dev: req_dev, rnw: req_rnw, alen: req_alen,
                                 addr: req_addr, len: req_len};
                    dev_eff <= fold_dev(req_dev, req_addr, req_alen, DEV_OVF_MASK);
                    aidx    <= req_alen[IDX_W-1:0] - IDX_W'(1);
                    cnt     <= '0;
                end
                S_ADR: if (bc_done && !bc_nack) aidx <= aidx - IDX_W'(1);
                S_WFETCH: if (wr_valid) wbyte <= wr_data;
                S_WR: if (bc_done && !bc_nack) cnt <= cnt + LEN_W'(1);
                S_RD: if (bc_done) begin
                    cnt        <= cnt + LEN_W'(1);
                    rd_valid_q <= 1'b1;
                    rd_data_q  <= bc_rxbyte;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk
    import i2cs_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req_start,
    input logic [2:0]  req_alen,
    input logic [15:0] req_len,
    input logic        busy,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic        rd_valid,
    input logic        done,
    input logic [1:0]  status,
    input logic        bus_busy,
    input logic        bc_cmd_valid,
    input logic [2:0]  bc_cmd,
    input logic        bc_done
);
    AST_BAD_REJECT: assert property (@(posedge clk) disable iff (rst)
        (req_start && !busy && (req_len == 16'd0 || req_alen > 3'd4)) |=> (done && status == 2'd3 && !bc_cmd_valid)); // R1

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_busy && !bc_cmd_valid) |=> !bc_cmd_valid); // R2

    AST_READ_STROBE: assert property (@(posedge clk) disable iff (rst)
        (bc_cmd_valid && bc_cmd == 3'd3 && bc_done) |=> rd_valid); // R6

    AST_STOP_BEFORE_DONE: assert property (@(posedge clk) disable iff (rst)
        (done && (status == 2'd0 || status == 2'd1)) |-> $past(bc_cmd_valid && bc_cmd == 3'd4)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_ready && !wr_valid) |=> wr_ready); // R10
endmodule

bind i2c_regxfer_seq i2cs_chk u_chk (
    .clk(clk), .rst(rst), .req_start(req_start), .req_alen(req_alen), .req_len(req_len),
    .busy(busy), .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_valid(rd_valid),
    .done(done), .status(status), .bus_busy(bus_busy), .bc_cmd_valid(bc_cmd_valid),
    .bc_cmd(bc_cmd), .bc_done(bc_done)
);

// File: tb/tb_i2c_regxfer_seq.sv
`timescale 1ns/1ps
module tb_i2c_regxfer_seq;
    localparam int         BUSY_TMO = 30;
    localparam int         BYTE_TMO = 40;
    localparam logic [6:0] OVF      = 7'h03;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_start = 1'b0;
    logic [6:0]  req_dev = '0;
    logic        req_rnw = 1'b0;
    logic [2:0]  req_alen = '0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic busy, wr_ready, rd_valid, done, bc_cmd_valid, bc_ack_en;
    logic wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data, bc_txbyte;
    logic [1:0] status;
    logic [2:0] bc_cmd;
    logic bus_busy = 1'b0;
    logic bc_done = 1'b0, bc_nack = 1'b0;
    logic [7:0] bc_rxbyte = '0;

    always #5 clk = ~clk;

    i2c_regxfer_seq #(.BUSY_TMO_CYC(BUSY_TMO), .BYTE_TMO_CYC(BYTE_TMO), .DEV_OVF_MASK(OVF)) dut (
        .clk(clk), .rst(rst), .req_start(req_start), .req_dev(req_dev), .req_rnw(req_rnw),
        .req_alen(req_alen), .req_addr(req_addr), .req_len(req_len), .busy(busy),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .status(status),
        .bus_busy(bus_busy), .bc_cmd_valid(bc_cmd_valid), .bc_cmd(bc_cmd),
        .bc_txbyte(bc_txbyte), .bc_ack_en(bc_ack_en), .bc_done(bc_done),
        .bc_nack(bc_nack), .bc_rxbyte(bc_rxbyte)
    );

    int checks = 0;
    int fails  = 0;
    logic [10:0] exp_q[$];   // {cmd, byte}; READ byte = ack flag
    logic [7:0]  rd_q[$];
    logic [7:0]  wq[$];
    int ev_cnt = 0, rd_cnt = 0;
    int nack_ev = -1, hang_ev = -1;
    bit stall = 1'b0;
    bit fire = 1'b0;
    bit gap = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Byte-engine model and bus-command scoreboard monitor.
    always begin
        @(negedge clk);
        if (!rst && bc_cmd_valid) begin
            logic [2:0]  c;
            logic [10:0] got, want;
            c   = bc_cmd;
            got = {c, (c == 3'd3) ? {7'b0, bc_ack_en} : bc_txbyte};
            if (exp_q.size() == 0)
                chk(1'b0, "R9", "unexpected command", 32'(got), 32'h0);
            else begin
                want = exp_q.pop_front();
                chk(got == want, "R3/R4/R5", "bus command", 32'(got), 32'(want));
            end
            if (ev_cnt == hang_ev) begin
                ev_cnt++;
                while (bc_cmd_valid && bc_cmd == c) @(negedge clk);
            end else begin
                repeat (2) @(negedge clk);
                bc_nack   = (ev_cnt == nack_ev) || (c == 3'd3 && !bc_ack_en);
                bc_rxbyte = 8'hA0 + 8'(rd_cnt);
                if (c == 3'd3) rd_cnt++;
                ev_cnt++;
                bc_done = 1'b1;
                @(negedge clk);
                bc_done = 1'b0;
                bc_nack = 1'b0;
            end
        end
    end

    // Read-stream monitor.
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (rd_q.size() == 0)
                chk(1'b0, "R6", "unexpected rd_valid", 32'(rd_data), 32'h0);
            else begin
                logic [7:0] e;
                e = rd_q.pop_front();
                chk(rd_data == e, "R6", "read byte", 32'(rd_data), 32'(e));
            end
        end
    end

    // Write-stream source.
    always @(negedge clk) begin
        if (fire && wq.size() > 0) void'(wq.pop_front());
        fire = wr_valid && wr_ready;
        gap  = stall ? !gap : 1'b0;
        wr_valid = (wq.size() > 0) && !gap;
        wr_data  = (wq.size() > 0) ? wq[0] : 8'h00;
        fire = fire && 1'b1;
        if (!wr_valid) fire = 1'b0;
        else fire = wr_ready;
    end

    task automatic run(input string req, input logic [6:0] dev, input bit rnw,
                       input logic [2:0] alen, input logic [31:0] addr, input logic [15:0] len,
                       input int nev, input int hev, input int busy_cyc);
        logic [10:0] evs[$];
        logic [6:0]  dx;
        logic [1:0]  exp_st;
        int          nread;
        int          wait_n;
        exp_q.delete(); rd_q.delete(); wq.delete();
        ev_cnt = 0; rd_cnt = 0; nack_ev = nev; hang_ev = hev;
        dx = dev;
        if (alen > 0 && alen < 4) dx = dev | (OVF & 7'(addr >> (8 * alen)));
        exp_st = 2'd0;
        if (len == 0 || alen > 4)
            exp_st = 2'd3;
        else if (busy_cyc < 0)
            exp_st = 2'd2;
        else begin
            evs.push_back({3'd1, dx, rnw && alen == 0});
            for (int i = int'(alen) - 1; i >= 0; i--) evs.push_back({3'd2, addr[8*i +: 8]});
            if (rnw && alen > 0) evs.push_back({3'd1, dx, 1'b1});
            for (int k = 0; k < int'(len); k++) begin
                if (rnw) evs.push_back({3'd3, 7'b0, k != int'(len) - 1});
                else begin
                    evs.push_back({3'd2, 8'h30 + 8'(k)});
                    wq.push_back(8'h30 + 8'(k));
                end
            end
            nread = 0;
            foreach (evs[e]) begin
                exp_q.push_back(evs[e]);
                if (e == hev) begin exp_st = 2'd2; break; end
                if (evs[e][10:8] == 3'd3) begin
                    rd_q.push_back(8'hA0 + 8'(nread));
                    nread++;
                end
                if (e == nev && !(evs[e][10:8] == 3'd3 && evs[e][0] == 1'b0)) begin
                    exp_st = 2'd1; break;
                end
            end
            exp_q.push_back({3'd4, 8'h00});
        end
        bus_busy = (busy_cyc != 0);
        @(negedge clk);
        req_dev = dev; req_rnw = rnw; req_alen = alen; req_addr = addr; req_len = len;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        if (busy_cyc > 0) begin
            repeat (busy_cyc - 1) @(negedge clk);
            chk(exp_q.size() == 0 || exp_q[0] == evs[0], "R2", "no command while busy",
                32'(bc_cmd_valid), 32'h0);
            chk(!bc_cmd_valid, "R2", "idle while bus busy", 32'(bc_cmd_valid), 32'h0);
            bus_busy = 1'b0;
        end
        wait_n = 0;
        while (!done && wait_n < 3000) begin @(negedge clk); wait_n++; end
        chk(done, req, "done reached (watchdog)", 32'(done), 32'h1);
        chk(status == exp_st, req, "status", 32'(status), 32'(exp_st));
        @(negedge clk);
        chk(!done, "R9", "done is one cycle", 32'(done), 32'h0);
        chk(exp_q.size() == 0, req, "commands left unissued", 32'(exp_q.size()), 32'h0);
        chk(rd_q.size() == 0, "R6", "reads left unseen", 32'(rd_q.size()), 32'h0);
        bus_busy = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !busy && !bc_cmd_valid && !wr_ready && !rd_valid, "R9", "reset state",
            {27'b0, done, busy, bc_cmd_valid, wr_ready, rd_valid}, 32'h0);
        stall = 1'b1;
        run("R10", 7'h50, 1'b0, 3'd2, 32'h0000_1234, 16'd3, -1, -1, 0);   // R4 R10 write, stalled stream
        stall = 1'b0;
        run("R5",  7'h50, 1'b1, 3'd1, 32'h0000_0007, 16'd3, -1, -1, 0);   // R5 R6 combined read
        run("R12", 7'h3C, 1'b1, 3'd0, 32'h0, 16'd1, -1, -1, 0);           // R12 probe present, R3 dir=1
        run("R12", 7'h3C, 1'b1, 3'd0, 32'h0, 16'd1, 0, -1, 0);            // R12 probe absent
        run("R1",  7'h50, 1'b0, 3'd1, 32'h0, 16'd0, -1, -1, 0);           // R1 zero count
        run("R1",  7'h50, 1'b1, 3'd5, 32'h0, 16'd2, -1, -1, 0);           // R1 alen too large
        run("R2",  7'h50, 1'b0, 3'd1, 32'h0000_0001, 16'd1, -1, -1, -1);  // R2 busy timeout
        run("R2",  7'h50, 1'b0, 3'd1, 32'h0000_0001, 16'd2, -1, -1, 10);  // R2 busy then free
        run("R7",  7'h50, 1'b0, 3'd2, 32'h0000_ABCD, 16'd2, 2, -1, 0);    // R7 nack on address
        run("R8",  7'h50, 1'b0, 3'd1, 32'h0000_0010, 16'd3, -1, 3, 0);    // R8 hang on write data
        run("R7",  7'h50, 1'b1, 3'd1, 32'h0000_0020, 16'd3, 3, -1, 0);    // R7 nack mid read
        run("R11", 7'h50, 1'b0, 3'd1, 32'h0000_0205, 16'd1, -1, -1, 0);  // R11 folded target
        run("R11", 7'h50, 1'b1, 3'd4, 32'hFFFF_FFFF, 16'd2, -1, -1, 0);  // R11 R4 four bytes, no fold
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule